// File: doc/BRIEF.md
# Channel-Major Logic Sample Packer

The block takes a 16-bit parallel logic sample stream and re-arranges it channel by channel. A sample strobe, derived from the base clock by an integer divide ratio, picks samples off the input. Every 64 strobes form one group. At the end of a group, each enabled channel's 64 bits are packed into one 64-bit word. Bit k of that word is the channel's k-th sample in the group. The words leave on a valid/ready port, one per enabled channel, in ascending channel order. Disabled channels are skipped.

Software loads the channel mask, the divide ratio and a sample count (in units of 16 samples), then pulses `start`. The divide ratio is meant to be ceil(100 MHz / requested rate). Capture runs into two alternating group banks, so sampling goes on while the previous group drains. When the count runs out, a partly filled group is zero-padded and emitted. `done` rises once the last word has been accepted.

Top module: `sample_packer`

## Requirements
- R1: A group holds exactly 64 consecutive captured samples; bit k of a channel's output word is that channel's k-th sample of the group, bit 0 being the earliest.
- R2: Per group, one word is emitted per enabled channel (a set bit of `chan_mask` enables channel i = bit i). Words go out lowest channel first, with `out_chan` giving the index. Disabled channels produce no word. All words of a group precede those of the next group.
- R3: If the sample count ends inside a group, the unfilled high bits of that group's words are zero, and the group is still emitted.
- R4: With the start accepted at clock edge E0 and divide ratio D (0 treated as 1), sample j (from 0) is the value of `sample_in` at edge E0 + D*(j+1).
- R5: The total number of captured samples is 16 times `count16`.
- R6: While `out_valid` is high and `out_ready` low, `out_valid`, `out_data` and `out_chan` hold steady. A word is consumed on an edge where both are high.
- R7: If capture needs a bank whose group has not been fully drained, `overflow` sets and stays set until the next accepted start. Capture stops. Groups already complete are still drained, and then `done` rises.
- R8: A start with a zero channel mask or a zero count emits nothing. It raises `done` on the edge that samples the start, with `busy` low.
- R9: A `start` pulse while `busy` is high is ignored and does not change the run in progress.
- R10: After reset, `out_valid`, `busy`, `done` and `overflow` are low.
- R11: `done` rises after the final word is accepted, with `busy` falling on the same edge. It stays high, with no output, until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Pulse to load settings and begin a run |
| chan_mask | input | 16 | Channel enable, bit i enables channel i |
| rate_div | input | 32 | Base clocks per sample strobe (0 acts as 1) |
| count16 | input | 32 | Samples to capture, in units of 16 |
| sample_in | input | 16 | Parallel logic sample |
| out_valid | output | 1 | Output word present |
| out_ready | input | 1 | Consumer accepts the word |
| out_data | output | 64 | 64 samples of one channel |
| out_chan | output | 4 | Channel index of `out_data` |
| busy | output | 1 | Run in progress |
| done | output | 1 | Run finished, all words delivered |
| overflow | output | 1 | A bank was needed before it drained |

## Verification
The assertions assume that `out_ready` is a level the consumer may drop at any time. They also assume that the settings ports only matter on the cycle a start is accepted, and that `start` is sampled on a single edge. The stimulus changes `sample_in`, `out_ready` and `start` only on falling edges, so every setting is stable at the sampling edge. Ready is held high, toggled in a fixed pattern, or held low long enough to force a bank collision. A start pulse issued mid-run carries different settings, to show that it has no effect.

// File: rtl/sp_pkg.sv
// Shared constants and helpers for the sample packer.
// Assumes channel counts never exceed SP_MAX_CH.
package sp_pkg;
    localparam int SP_MAX_CH = 64;

    // Index of the lowest set bit; 0 when the vector is empty.
    function automatic int unsigned sp_first_one(input logic [SP_MAX_CH-1:0] v);
        int unsigned r;
        r = 0;
        for (int i = SP_MAX_CH - 1; i >= 0; i--) begin
            if (v[i]) r = i;
        end
        return r;
    endfunction
endpackage

// File: rtl/sp_strobe.sv
// Sample strobe generator: one pulse every DIV base clocks while enabled.
// Assumes div is held constant while en is high; div of 0 behaves as 1.
module sp_strobe #(
    parameter int DIV_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [DIV_W-1:0] div,
    output logic             strobe
);
    logic [DIV_W-1:0] cnt;
    logic [DIV_W-1:0] lim;

    assign lim    = (div == '0) ? '0 : div - 1'b1;
    assign strobe = en && (cnt == lim);

    // Count base clocks between strobes; idle at zero when disabled.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) cnt <= '0;
        else if (strobe)   cnt <= '0;
        else               cnt <= cnt + 1'b1;
    end

    AST_STROBE_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe && lim != '0) |=> !strobe); // R4
endmodule

// File: rtl/sp_capture.sv
// Capture side: writes each strobed sample into the current group bank,
// hands a bank over when it holds a full or final group, flags overflow.
// Assumes bank_full is set by the owner on the same edge fill is high.
module sp_capture #(
    parameter int CH    = 16,
    parameter int GRP   = 64,
    parameter int CNT_W = 32,
    localparam int CHW   = $clog2(CH),
    localparam int IDX_W = $clog2(GRP),
    localparam int SMP_W = CNT_W + 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             go,
    input  logic [CNT_W-1:0] count16,
    input  logic             strobe,
    input  logic [CH-1:0]    sample,
    input  logic [1:0]       bank_full,
    input  logic             rd_bank,
    input  logic [CHW-1:0]   rd_ch,
    output logic [GRP-1:0]   rd_data,
    output logic             active,
    output logic             fill,
    output logic             fill_bank,
    output logic             overflow
);
    logic [IDX_W-1:0] idx;
    logic [SMP_W-1:0] left;
    logic             wb;
    logic             full_hit;
    logic             take;
    logic             last;
    logic [GRP-1:0]   ch_rd [CH];

    assign full_hit  = (idx == '0) && bank_full[wb];
    assign take      = strobe && active && !full_hit;
    assign last      = (left == SMP_W'(1));
    assign fill      = take && ((idx == IDX_W'(GRP - 1)) || last);
    assign fill_bank = wb;
    assign rd_data   = ch_rd[rd_ch];

    // Sequence sample index, remaining count and write bank.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= 1'b0; idx <= '0; left <= '0; wb <= 1'b0; overflow <= 1'b0;
        end else if (go) begin
            active <= 1'b1; idx <= '0; wb <= 1'b0; overflow <= 1'b0;
            left   <= {count16, 4'b0000};
        end else if (strobe && active) begin
            if (full_hit) begin
                overflow <= 1'b1;
                active   <= 1'b0;
            end else begin
                left <= left - 1'b1;
                if (fill) begin
                    idx <= '0;
                    wb  <= ~wb;
                    if (last) active <= 1'b0;
                end else begin
                    idx <= idx + 1'b1;
                end
            end
        end
    end

    for (genvar c = 0; c < CH; c++) begin : g_lane
        logic [GRP-1:0] bank0, bank1;
        // Store one sample bit of this channel; the first bit clears the word.
        always_ff @(posedge clk) begin
            if (take && !wb) begin
                if (idx == '0) bank0 <= {{(GRP-1){1'b0}}, sample[c]};
                else           bank0[idx] <= sample[c];
            end
            if (take && wb) begin
                if (idx == '0) bank1 <= {{(GRP-1){1'b0}}, sample[c]};
                else           bank1[idx] <= sample[c];
            end
        end
        assign ch_rd[c] = rd_bank ? bank1 : bank0;
    end

    AST_FILL_FREE_BANK: assert property (@(posedge clk) disable iff (!rst_n)
        fill |-> !bank_full[fill_bank]); // R7
    AST_OVF_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe && active && full_hit) |=> (overflow && !active)); // R7
endmodule

// File: rtl/sp_drain.sv
// Drain side: walks the enabled channels of a full bank in ascending
// order, presenting one word per channel, then releases the bank.
// Assumes the mask is non-zero whenever a bank is full.
module sp_drain #(
    parameter int CH = 16,
    localparam int CHW = $clog2(CH)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           clr,
    input  logic [CH-1:0]  mask,
    input  logic [1:0]     bank_full,
    input  logic           out_ready,
    output logic           out_valid,
    output logic [CHW-1:0] out_chan,
    output logic           rd_bank,
    output logic           free,
    output logic           free_bank,
    output logic           active
);
    import sp_pkg::*;

    logic [CH-1:0] pend;
    logic [CH-1:0] sel;

    assign out_chan  = CHW'(sp_first_one(SP_MAX_CH'(pend)));
    assign sel       = CH'(1) << out_chan;
    assign out_valid = active;
    assign rd_bank   = free_bank;
    assign free      = active && out_ready && ((pend & ~sel) == '0);

    // Claim a full bank, retire one channel per accepted word.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            active <= 1'b0; pend <= '0; free_bank <= 1'b0;
        end else if (!active && bank_full[free_bank]) begin
            active <= 1'b1;
            pend   <= mask;
        end else if (active && out_ready) begin
            pend <= pend & ~sel;
            if (free) begin
                active    <= 1'b0;
                free_bank <= ~free_bank;
            end
        end
    end

    AST_VALID_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_chan))); // R6
    AST_CHAN_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> mask[out_chan]); // R2
endmodule

// File: rtl/sample_packer.sv
// Top: latches run settings on start, owns the bank-full flags and the
// busy/done status, and ties strobe, capture and drain together.
// Assumes settings ports are only meaningful on the cycle start is taken.
module sample_packer #(
    parameter int CH    = 16,
    parameter int GRP   = 64,
    parameter int DIV_W = 32,
    parameter int CNT_W = 32,
    localparam int CHW  = $clog2(CH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [CH-1:0]    chan_mask,
    input  logic [DIV_W-1:0] rate_div,
    input  logic [CNT_W-1:0] count16,
    input  logic [CH-1:0]    sample_in,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [GRP-1:0]   out_data,
    output logic [CHW-1:0]   out_chan,
    output logic             busy,
    output logic             done,
    output logic             overflow
);
    logic [CH-1:0]    mask_q;
    logic [DIV_W-1:0] div_q;
    logic [1:0]       bank_full;
    logic             go, zero_go, strobe;
    logic             cap_active, fill, fill_bank;
    logic             free, free_bank, rd_bank, drn_active;

    assign go      = start && !busy && (chan_mask != '0) && (count16 != '0);
    assign zero_go = start && !busy && !((chan_mask != '0) && (count16 != '0));

    // Latch the run settings when a start is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= '0; div_q <= '0;
        end else if (go) begin
            mask_q <= chan_mask; div_q <= rate_div;
        end
    end

    // Track which banks hold a group waiting to be drained.
    always_ff @(posedge clk) begin
        if (!rst_n || go) begin
            bank_full <= '0;
        end else begin
            for (int b = 0; b < 2; b++) begin
                if (fill && (fill_bank == b[0]))      bank_full[b] <= 1'b1;
                else if (free && (free_bank == b[0])) bank_full[b] <= 1'b0;
            end
        end
    end

    // Run status: busy from start until every word has left.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0; done <= 1'b0;
        end else if (go) begin
            busy <= 1'b1; done <= 1'b0;
        end else if (zero_go) begin
            done <= 1'b1;
        end else if (busy && !cap_active && (bank_full == '0) && !drn_active) begin
            busy <= 1'b0; done <= 1'b1;
        end
    end

    sp_strobe #(.DIV_W(DIV_W)) u_strobe (
        .clk(clk), .rst_n(rst_n), .en(cap_active), .div(div_q), .strobe(strobe)
    );

    sp_capture #(.CH(CH), .GRP(GRP), .CNT_W(CNT_W)) u_capture (
        .clk(clk), .rst_n(rst_n), .go(go), .count16(count16), .strobe(strobe),
        .sample(sample_in), .bank_full(bank_full), .rd_bank(rd_bank),
        .rd_ch(out_chan), .rd_data(out_data), .active(cap_active), .fill(fill),
        .fill_bank(fill_bank), .overflow(overflow)
    );

    sp_drain #(.CH(CH)) u_drain (
        .clk(clk), .rst_n(rst_n), .clr(go), .mask(mask_q), .bank_full(bank_full),
        .out_ready(out_ready), .out_valid(out_valid), .out_chan(out_chan),
        .rd_bank(rd_bank), .free(free), .free_bank(free_bank), .active(drn_active)
    );

    AST_DATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> $stable(out_data)); // R6
    AST_ZERO_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        zero_go |=> (done && !busy && !out_valid)); // R8
    AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (start && busy) |=> $stable(mask_q)); // R9
    AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!out_valid && !busy)); // R11
endmodule

// File: tb/tb_sample_packer.sv
// Behavioural reference bench: expected words are built in a queue from
// the sample function and compared at every accepted handshake.
module tb_sample_packer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [15:0] chan_mask = '0;
    logic [31:0] rate_div = '0;
    logic [31:0] count16 = '0;
    logic [15:0] sample_in = '0;
    logic        out_valid, out_ready = 1'b0;
    logic [63:0] out_data;
    logic [3:0]  out_chan;
    logic        busy, done, overflow;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int rmode = 0;
    logic [67:0] expq[$];
    logic        held = 1'b0;
    logic [67:0] held_val = '0;

    sample_packer dut (
        .clk(clk), .rst_n(rst_n), .start(start), .chan_mask(chan_mask),
        .rate_div(rate_div), .count16(count16), .sample_in(sample_in),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
        .out_chan(out_chan), .busy(busy), .done(done), .overflow(overflow)
    );

    always #2 clk = ~clk;
    always @(posedge clk) cyc++;

    function automatic logic [15:0] h(input int n);
        int x;
        x = n * 40503 + 12345;
        return x[15:0] ^ x[27:12];
    endfunction

    task automatic chk(input bit ok, input string req, input logic [67:0] act, input logic [67:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Drive samples and ready; compare accepted words with the model.
    always @(negedge clk) begin
        logic r;
        logic [67:0] got;
        sample_in <= h(cyc + 1);
        r = (rmode == 0) ? 1'b1 : (rmode == 1) ? ((cyc % 3) != 2) : 1'b0;
        out_ready <= r;
        got = {out_chan, out_data};
        if (rst_n && held) chk(out_valid && got == held_val, "R6 hold", got, held_val);
        held = rst_n && out_valid && !r;
        held_val = got;
        if (rst_n && out_valid && r) begin
            if (expq.size() == 0) chk(1'b0, "R2 extra word", got, '0);
            else begin
                logic [67:0] e;
                e = expq.pop_front();
                chk(got == e, "R1/R2/R3/R4 word", got, e);
            end
        end
    end

    task automatic build(input logic [15:0] m, input int dv, input int total, input int e0);
        int d;
        d = (dv == 0) ? 1 : dv;
        for (int g = 0; g * 64 < total; g++) begin
            for (int ch = 0; ch < 16; ch++) begin
                if (m[ch]) begin
                    logic [63:0] w;
                    w = '0;
                    for (int k = 0; k < 64; k++) begin
                        logic [15:0] s;
                        if (g * 64 + k < total) begin
                            s = h(e0 + d * (g * 64 + k + 1));
                            w[k] = s[ch];
                        end
                    end
                    expq.push_back({ch[3:0], w});
                end
            end
        end
    endtask

    task automatic launch(input logic [15:0] m, input int dv, input int c16, input int total);
        @(negedge clk);
        chan_mask = m; rate_div = dv; count16 = c16; start = 1'b1;
        build(m, dv, total, cyc + 1);
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_done(input string req);
        int n;
        n = 0;
        while (!done && n < 20000) begin
            @(negedge clk);
            n++;
        end
        chk(done && !busy, req, {66'b0, done, busy}, 68'h2);
        chk(expq.size() == 0, req, expq.size(), 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual running expected finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R10: reset state
        chk({out_valid, busy, done, overflow} == 4'b0, "R10 reset", {out_valid, busy, done, overflow}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R1, R5: one channel, one full group
        rmode = 0;
        launch(16'h0001, 1, 4, 64);
        wait_done("R5 single group");
        repeat (10) @(negedge clk);
        // R11: done persists with no output
        chk(done && !out_valid, "R11 done held", {out_valid, done}, 2'b01);

        // R2, R9: sparse mask, two groups, gated ready, ignored restart
        rmode = 1;
        launch(16'hA5C3, 3, 8, 128);
        repeat (50) @(negedge clk);
        chk(busy, "R9 busy", busy, 1);
        chan_mask = 16'hFFFF; count16 = 1; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_done("R9 restart ignored");

        // R3: partial final group padded with zeros
        launch(16'hFFFF, 2, 5, 80);
        wait_done("R3 partial group");

        // R4: divider zero behaves as one
        rmode = 0;
        launch(16'h8001, 0, 4, 64);
        wait_done("R4 zero divider");

        // R8: zero mask and zero count
        @(negedge clk);
        chan_mask = 16'h0000; count16 = 4; rate_div = 1; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(done && !busy, "R8 zero mask", {done, busy}, 2'b10);
        chan_mask = 16'h0001; count16 = 0; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(done && !busy, "R8 zero count", {done, busy}, 2'b10);
        repeat (20) @(negedge clk);
        chk(!out_valid && expq.size() == 0, "R8 no output", out_valid, 0);

        // R7: stalled consumer forces a bank collision
        rmode = 2;
        launch(16'h0001, 1, 20, 128);
        repeat (400) @(negedge clk);
        chk(overflow, "R7 overflow set", overflow, 1);
        chk(busy && !done, "R7 still busy", {busy, done}, 2'b10);
        rmode = 0;
        wait_done("R7 drained");
        chk(overflow, "R7 sticky", overflow, 1);

        // R7: new start clears the flag
        launch(16'h0010, 1, 4, 64);
        chk(!overflow, "R7 cleared", overflow, 0);
        wait_done("R1 after overflow");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule